// File: doc/BRIEF.md
# Subroutine Call/Return Sequencer

This block handles the control-flow side of subroutine linkage for a small processor core. When an instruction is presented together with its own address, the block recognises three encodings: a two-byte long call that carries an 11-bit absolute target, a one-byte short call that jumps to a fixed vector picked by a 4-bit index, and a one-byte return. For calls it saves the address of the following instruction in a private hardware stack of return addresses. For returns it takes that address back. In both cases it hands the new program counter to the fetch logic.

Each of the three operations takes two cycles. In the first cycle the block captures and decodes the bytes. In the second it updates the stack and the stack pointer, and it then issues a one-cycle load pulse with the new PC. A push writes at the current stack pointer and then moves the pointer down. A pop moves the pointer up and then reads. The pointer wraps at both ends of the stack, and a wrap is reported by a fault pulse that comes with the PC load. Any other byte pattern is left alone.

Top module: `callret_sequencer`

## Requirements
- R1: A long call has first byte `0100_0aaa` and second byte `aaaa_aaaa`. Its target is the 11 bits {first[2:0], second}, zero-extended. The op is accepted on the edge where `op_valid` is high and `busy` is low. On the next edge `pc_load` rises for one cycle, and `pc_next` equals the target.
- R2: A short call is the single byte `1110_nnnn`. It loads `pc_next` with 8·n+6 for n from 1 to 15, and with 0x086 for n equal to 0. The timing is the same as in R1.
- R3: A call writes a return address into the stack entry selected by `sp` and then decrements `sp`. The return address is `pc_in`+2 for a long call and `pc_in`+1 for a short call, modulo 2^PC_W.
- R4: A return (byte `0100_1111`) first increments `sp` and then loads `pc_next` with the entry at the new `sp`. Nested calls therefore come back in last-in, first-out order.
- R5: `busy` is high for exactly the one cycle after an accepting edge. While `busy` is high, `op_valid` is ignored.
- R6: Any first byte that matches none of the three encodings does nothing. No `pc_load` follows, and `sp` does not change.
- R7: After a synchronous active-low reset, `sp` equals DEPTH-1, `busy`, `pc_load` and `stk_fault` are low, `pc_next` is 0, and every stack entry reads 0.
- R8: A push at `sp`=0 wraps `sp` to DEPTH-1. A pop at `sp`=DEPTH-1 wraps `sp` to 0. In either case `stk_fault` is high in the same cycle as that operation's `pc_load` pulse, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An instruction's bytes and address are presented |
| op_byte0 | input | 8 | First instruction byte |
| op_byte1 | input | 8 | Second instruction byte (used by long call only) |
| pc_in | input | PC_W | Address of the presented instruction |
| busy | output | 1 | Sequencer is executing the captured operation |
| pc_load | output | 1 | One-cycle pulse: `pc_next` holds the new PC |
| pc_next | output | PC_W | New program counter |
| sp | output | $clog2(DEPTH) | Current stack pointer |
| stk_fault | output | 1 | Stack pointer wrapped during the operation now loading |

## Verification
The hardest state to reach from the ports is a pointer wrap at either end of the stack, with a stale or reset entry being read back. It needs an unbroken run of more than DEPTH calls, or of returns with no matching calls. The directed stimulus therefore issues DEPTH+1 nested calls followed by DEPTH+2 returns, so that `sp` crosses both boundaries. Long random mixes follow, in which encoded and stray bytes are also offered while `busy` is high. Every cycle is compared against a behavioural model that keeps its own stack.

// File: rtl/callret_pkg.sv
// Shared encodings and helpers for the call/return sequencer.
// Assumes byte-wide opcodes; vector addresses fit in 12 bits.
package callret_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LCALL = 2'd1,
        OP_SCALL = 2'd2,
        OP_RET   = 2'd3
    } op_kind_e;

    localparam logic [4:0] LCALL_PREFIX = 5'b01000;
    localparam logic [3:0] SCALL_PREFIX = 4'b1110;
    localparam logic [7:0] RET_CODE     = 8'b0100_1111;
    localparam int         VEC_W        = 12;
    localparam int         LTGT_W       = 11;

    // Short-call vector: 8n+6, with index 0 redirected to 0x086.
    function automatic logic [VEC_W-1:0] short_vector(input logic [3:0] idx);
        if (idx == 4'd0) return 12'h086;
        return {5'b00000, idx, 3'b110};
    endfunction

endpackage

// File: rtl/callret_decode.sv
// Combinational opcode decoder: classifies the presented bytes and
// forms the jump target and the return address for calls.
// Assumes PC_W >= 12 so every target fits without truncation.
module callret_decode
    import callret_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic [7:0]      byte0,
    input  logic [7:0]      byte1,
    input  logic [PC_W-1:0] pc_in,
    output op_kind_e        kind,
    output logic [PC_W-1:0] target,
    output logic [PC_W-1:0] ret_addr
);

    localparam logic [PC_W-1:0] LONG_LEN  = PC_W'(2);
    localparam logic [PC_W-1:0] SHORT_LEN = PC_W'(1);

    // Classify the opcode and form target and return address.
    always_comb begin
        kind     = OP_NONE;
        target   = '0;
        ret_addr = pc_in;
        if (byte0[7:3] == LCALL_PREFIX) begin
            kind                 = OP_LCALL;
            target[LTGT_W-1:0]   = {byte0[2:0], byte1};
            ret_addr             = pc_in + LONG_LEN;
        end else if (byte0[7:4] == SCALL_PREFIX) begin
            kind                 = OP_SCALL;
            target[VEC_W-1:0]    = short_vector(byte0[3:0]);
            ret_addr             = pc_in + SHORT_LEN;
        end else if (byte0 == RET_CODE) begin
            kind                 = OP_RET;
        end
    end

endmodule

// File: rtl/callret_stack.sv
// Return-address stack. A push writes at sp, then sp moves down.
// A pop moves sp up, and the entry at the new sp is presented on rdata.
// Assumes push and pop are never high together; sp wraps at both ends.
module callret_stack #(
    parameter int PC_W  = 12,
    parameter int DEPTH = 8,
    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] wdata,
    output logic [PC_W-1:0] rdata,
    output logic [SP_W-1:0] sp,
    output logic            wrap
);

    localparam logic [SP_W-1:0] SP_TOP = SP_W'(DEPTH - 1);

    logic [PC_W-1:0] mem [DEPTH];
    logic [SP_W-1:0] sp_dn;
    logic [SP_W-1:0] sp_up;

    // Neighbouring pointer values with explicit wrap for any depth.
    always_comb begin
        sp_dn = (sp == '0)     ? SP_TOP : sp - SP_W'(1);
        sp_up = (sp == SP_TOP) ? '0     : sp + SP_W'(1);
    end

    // Pop data comes from the entry the pointer is about to reach.
    assign rdata = mem[sp_up];
    // Wrap event: a push from the bottom or a pop from the top.
    assign wrap  = (push && sp == '0) || (pop && sp == SP_TOP);

    // Stack pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= SP_TOP;
        else if (push) sp <= sp_dn;
        else if (pop)  sp <= sp_up;
    end

    // Entry storage: cleared on reset, written at sp on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= wdata;
        end
    end

    AST_PUSH_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> mem[$past(sp)] == $past(wdata));                         // R3
    AST_PUSH_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (push && DEPTH > 1) |=> sp != $past(sp));                         // R3
    AST_POP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && DEPTH > 1) |=> sp != $past(sp));                          // R4
    AST_IDLE_HOLDS_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(sp));                                 // R6

endmodule

// File: rtl/callret_sequencer.sv
// Call/return sequencer top. It captures and decodes an instruction in
// its first cycle, then pushes or pops the return stack and issues a
// one-cycle PC load in its second cycle.
// Assumes pc_in is the address of the presented instruction's first byte.
module callret_sequencer
    import callret_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int DEPTH = 8,
    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [7:0]      op_byte0,
    input  logic [7:0]      op_byte1,
    input  logic [PC_W-1:0] pc_in,
    output logic            busy,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_next,
    output logic [SP_W-1:0] sp,
    output logic            stk_fault
);

    op_kind_e        dec_kind;
    logic [PC_W-1:0] dec_target;
    logic [PC_W-1:0] dec_ret;

    op_kind_e        kind_q;
    logic [PC_W-1:0] target_q;
    logic [PC_W-1:0] ret_q;
    logic            busy_q;
    logic            load_q;
    logic [PC_W-1:0] pc_q;
    logic            fault_q;

    logic            accept;
    logic            do_push;
    logic            do_pop;
    logic [PC_W-1:0] pop_data;
    logic            stk_wrap;

    callret_decode #(.PC_W(PC_W)) u_decode (
        .byte0    (op_byte0),
        .byte1    (op_byte1),
        .pc_in    (pc_in),
        .kind     (dec_kind),
        .target   (dec_target),
        .ret_addr (dec_ret)
    );

    callret_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_push),
        .pop   (do_pop),
        .wdata (ret_q),
        .rdata (pop_data),
        .sp    (sp),
        .wrap  (stk_wrap)
    );

    // Accept only recognised opcodes while no operation is running.
    assign accept  = op_valid && !busy_q && (dec_kind != OP_NONE);
    // Second-cycle stack actions, chosen by the captured kind.
    assign do_push = busy_q && (kind_q == OP_LCALL || kind_q == OP_SCALL);
    assign do_pop  = busy_q && (kind_q == OP_RET);

    // Capture stage: latch the decoded op and hold it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            kind_q   <= OP_NONE;
            target_q <= '0;
            ret_q    <= '0;
        end else if (busy_q) begin
            busy_q   <= 1'b0;
        end else if (accept) begin
            busy_q   <= 1'b1;
            kind_q   <= dec_kind;
            target_q <= dec_target;
            ret_q    <= dec_ret;
        end
    end

    // Execute stage: publish the new PC and any wrap as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= 1'b0;
            pc_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            load_q  <= busy_q;
            fault_q <= busy_q && stk_wrap;
            if (busy_q) pc_q <= (kind_q == OP_RET) ? pop_data : target_q;
        end
    end

    assign busy      = busy_q;
    assign pc_load   = load_q;
    assign pc_next   = pc_q;
    assign stk_fault = fault_q;

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);                                                  // R5
    AST_LOAD_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> pc_load);                                                // R5
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);                                            // R1
    AST_FAULT_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stk_fault |-> pc_load);                                           // R8
    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(op_valid && (op_byte0[7:3] == LCALL_PREFIX
            || op_byte0[7:4] == SCALL_PREFIX || op_byte0 == RET_CODE)))
        |=> !busy);                                                       // R6

endmodule

// File: tb/tb_callret_sequencer.sv
`timescale 1ns/1ps
module tb_callret_sequencer;

    localparam int PC_W  = 12;
    localparam int DEPTH = 8;
    localparam int SP_W  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [7:0]      op_byte0 = '0;
    logic [7:0]      op_byte1 = '0;
    logic [PC_W-1:0] pc_in = '0;
    logic            busy;
    logic            pc_load;
    logic [PC_W-1:0] pc_next;
    logic [SP_W-1:0] sp;
    logic            stk_fault;

    callret_sequencer #(.PC_W(PC_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .op_byte0(op_byte0), .op_byte1(op_byte1), .pc_in(pc_in),
        .busy(busy), .pc_load(pc_load), .pc_next(pc_next),
        .sp(sp), .stk_fault(stk_fault)
    );

    always #5 clk = ~clk;

    // Behavioural reference state.
    int     m_stack [DEPTH];
    int     m_sp, m_kind, m_target, m_ret;
    bit     m_busy;
    bit     e_load, e_fault;
    int     e_pc;
    string  pc_tag, sp_tag;
    int     vectors = 0, miscompares = 0;
    bit     done = 1'b0;

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_stack[i] = 0;
        m_sp = DEPTH - 1; m_busy = 0; m_kind = 0; m_target = 0; m_ret = 0;
        e_load = 0; e_fault = 0; e_pc = 0; pc_tag = "R7"; sp_tag = "R7";
    endtask

    // Predict the outputs after the next edge from the present inputs.
    task automatic model_tick(input bit v, input logic [7:0] b0, input logic [7:0] b1,
                              input int pc);
        e_load = 0; e_fault = 0; sp_tag = "R6";
        if (m_busy) begin
            m_busy = 0; e_load = 1;
            if (m_kind == 3) begin
                e_fault = (m_sp == DEPTH - 1);
                m_sp = e_fault ? 0 : m_sp + 1;
                e_pc = m_stack[m_sp]; pc_tag = "R4"; sp_tag = "R4";
            end else begin
                m_stack[m_sp] = m_ret;
                e_fault = (m_sp == 0);
                m_sp = e_fault ? DEPTH - 1 : m_sp - 1;
                e_pc = m_target; sp_tag = "R3";
                pc_tag = (m_kind == 1) ? "R1" : "R2";
            end
        end else if (v) begin
            if (b0[7:3] == 5'b01000) begin
                m_busy = 1; m_kind = 1;
                m_target = b0[2:0] * 256 + b1; m_ret = (pc + 2) % 4096;
            end else if (b0[7:4] == 4'b1110) begin
                m_busy = 1; m_kind = 2;
                m_target = (b0[3:0] == 0) ? 'h86 : b0[3:0] * 8 + 6;
                m_ret = (pc + 1) % 4096;
            end else if (b0 == 8'h4F) begin
                m_busy = 1; m_kind = 3;
            end
        end
    endtask

    task automatic check_all();
        vectors++;
        if (busy !== m_busy) begin
            miscompares++;
            $display("FAIL R5 busy actual=%0b expected=%0b", busy, m_busy);
        end
        if (pc_load !== e_load) begin
            miscompares++;
            $display("FAIL %s pc_load actual=%0b expected=%0b", pc_tag, pc_load, e_load);
        end
        if (pc_next !== PC_W'(e_pc)) begin
            miscompares++;
            $display("FAIL %s pc_next actual=%h expected=%h", pc_tag, pc_next, PC_W'(e_pc));
        end
        if (sp !== SP_W'(m_sp)) begin
            miscompares++;
            $display("FAIL %s sp actual=%0d expected=%0d", sp_tag, sp, m_sp);
        end
        if (stk_fault !== e_fault) begin
            miscompares++;
            $display("FAIL R8 stk_fault actual=%0b expected=%0b", stk_fault, e_fault);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; compare at the next.
    task automatic step(input bit v, input logic [7:0] b0, input logic [7:0] b1,
                        input int pc);
        op_valid = v; op_byte0 = b0; op_byte1 = b1; pc_in = PC_W'(pc);
        model_tick(v, b0, b1, pc);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 8'h00, 0);
    endtask

    function automatic logic [7:0] stray(input int k);
        case (k % 6)
            0: return 8'h00;
            1: return 8'h48;
            2: return 8'h4E;
            3: return 8'h50;
            4: return 8'hD7;
            default: return 8'hF3;
        endcase
    endfunction

    initial begin
        model_reset();
        @(negedge clk); @(negedge clk);
        check_all();                                   // R7 reset state
        rst_n = 1'b1;

        // R1: long calls with distinct targets, idle between.
        step(1, 8'h45, 8'hA3, 'h100); idle(); idle();
        step(1, 8'h47, 8'hFF, 'h7FE); idle(); idle();
        // R2: short calls n=0, 1, 15.
        step(1, 8'hE0, 8'h00, 'h200); idle(); idle();
        step(1, 8'hE1, 8'h00, 'h300); idle(); idle();
        step(1, 8'hEF, 8'h00, 'hFFF); idle(); idle();
        // R4: returns come back in reverse order; R5 op offered while busy.
        for (int i = 0; i < 5; i++) begin
            step(1, 8'h4F, 8'h00, 0);
            step(1, 8'h45, 8'h11, 'h010);              // ignored: busy
            idle();
        end
        // R6: stray bytes do nothing.
        for (int i = 0; i < 6; i++) step(1, stray(i), 8'h4F, i * 3);
        // R8: overflow by DEPTH+1 nested calls, then underflow.
        for (int i = 0; i < DEPTH + 1; i++) begin
            step(1, 8'hE0 | 8'(i % 16), 8'h00, 'h400 + i * 16); idle();
        end
        for (int i = 0; i < DEPTH + 2; i++) begin
            step(1, 8'h4F, 8'h00, 0); idle();
        end
        // Random mix, inputs offered every cycle, including while busy.
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 3)       step(1, 8'h40 | 8'($urandom_range(0, 7)), 8'($urandom), $urandom_range(0, 4095));
            else if (sel < 5)  step(1, 8'hE0 | 8'($urandom_range(0, 15)), 8'($urandom), $urandom_range(0, 4095));
            else if (sel < 8)  step(1, 8'h4F, 8'($urandom), $urandom_range(0, 4095));
            else if (sel == 8) step(1, stray($urandom_range(0, 5)), 8'($urandom), $urandom_range(0, 4095));
            else               idle();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule